// File: doc/BRIEF.md
# Digital Input Glitch Filter

This block conditions a bank of asynchronous digital inputs (24 by default) before they reach software and the change-detection logic. Each input is first brought into the clock domain through a two-flop synchronizer. Channels whose filter is switched on only pass a new level after the synchronized input has held that level for a programmed number of time quanta. Channels whose filter is off pass the synchronized level straight through. A free-running prescaler divides the system clock into a one-cycle tick, one tick per quantum. With the default divide of 10 on a 50 MHz clock, one quantum is 200 ns.

Software uses a byte-wide register port. It writes a shared stability interval of up to 20 bits into a staging register. The interval only becomes active when software writes a reload command. The same command register can also resynchronize every filter at once. Software sets a per-channel enable mask and reads back the filtered levels as bytes.

The inputs and the filtered bus are levels that are sampled every cycle. They carry no handshake, and no back-pressure applies to them. A register write completes in the cycle it is presented. A register read is combinational on the address.

Top module: `din_glitch_filter`

## Requirements
- R1: After reset the enable mask, the staged interval and the active interval are all zero, every channel is unfiltered, and any address outside the map reads 0x00.
- R2: An unfiltered channel's level appears on `filt_o` after exactly three rising clock edges: two synchronizer stages and one output stage.
- R3: Reads at 0x00, 0x01 and 0x02 return filtered channels 7..0, 15..8 and 23..16 (bit n of the byte is the lowest channel plus n). Reads at 0x08..0x0A return the staged interval bytes, least significant byte first. Bits 7..4 of the byte at 0x0A are discarded on write and read as zero.
- R4: Writing the interval bytes at 0x08..0x0A changes only the staged value. The active interval copies the staged value only on a write to 0x07 with bit 0 set.
- R5: A filtered channel with active interval N passes a new level only after the synchronized input has held it across N prescaler ticks. A ~~tick~~ tick is one clock cycle in every `TICK_DIV` clocks. A level held for fewer than N-1 ticks never reaches `filt_o`, and a filtered output changes only in a tick cycle.
- R6: Whenever the synchronized input returns to the filtered level, the channel's stability count starts again from zero.
- R7: An active interval of zero makes enabled channels behave as unfiltered, with the three-edge latency of R2.
- R8: A write to 0x07 with bit 1 set loads every channel's output from its synchronized input at that clock edge and clears every stability count.
- R9: Channel c is filtered only when bit c%8 of the enable byte at 0x0C + c/8 is set. Each channel's filtering is independent of the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din_i | input | N_CH | Raw asynchronous input levels |
| reg_wr_i | input | 1 | Register write strobe, one write per cycle |
| reg_addr_i | input | 5 | Register byte address (write and read) |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational on address |
| filt_o | output | N_CH | Filtered levels to change-detection logic |

## Verification
The bench measures the synchronizer latency edge by edge. A design with one stage too many or too few would show the level a cycle late or early. It proves that a staged interval stays inert until the reload command by showing that an enabled channel still passes a short pulse. It feeds a bounce that splits one long high period into two short ones, which a design that fails to restart its count would wrongly pass. It also checks that the upper nibble of the interval is discarded, that the clear command snaps outputs to the inputs in the same edge, and that the enable of one channel leaves its neighbour unfiltered.

// File: rtl/dinflt_pkg.sv
package dinflt_pkg;
  localparam int unsigned REG_AW = 5;
  localparam logic [REG_AW-1:0] OFS_LEVEL = 5'h00;
  localparam logic [REG_AW-1:0] OFS_CMD   = 5'h07;
  localparam logic [REG_AW-1:0] OFS_IVAL  = 5'h08;
  localparam logic [REG_AW-1:0] OFS_ENA   = 5'h0C;
  localparam int unsigned CMD_RELOAD_BIT = 0;
  localparam int unsigned CMD_CLEAR_BIT  = 1;
endpackage

// File: rtl/dinflt_tick.sv
module dinflt_tick #(
  parameter int unsigned TICK_DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int unsigned CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

  generate
    if (TICK_DIV > 1) begin : g_chk
      // R5: a tick lasts a single cycle
      p_tick_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/dinflt_regs.sv
module dinflt_regs
  import dinflt_pkg::*;
#(
  parameter int unsigned N_CH   = 24,
  parameter int unsigned IVAL_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic [N_CH-1:0]   level_i,
  output logic [N_CH-1:0]   ena_o,
  output logic [IVAL_W-1:0] ival_o,
  output logic              clear_o
);
  localparam int unsigned NB = N_CH / 8;
  localparam int unsigned IB = (IVAL_W + 7) / 8;
  localparam logic [IB*8-1:0] IMASK = {(IB*8){1'b1}} >> (IB*8 - IVAL_W);

  logic [IB*8-1:0]   stage_q;
  logic [N_CH-1:0]   ena_q;
  logic [IVAL_W-1:0] act_q;
  logic              cmd_wr;
  logic              reload;

  assign cmd_wr  = reg_wr_i && (reg_addr_i == OFS_CMD);
  assign reload  = cmd_wr && reg_wdata_i[CMD_RELOAD_BIT];
  assign clear_o = cmd_wr && reg_wdata_i[CMD_CLEAR_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      ena_q   <= '0;
      act_q   <= '0;
    end else begin
      if (reg_wr_i) begin
        for (int b = 0; b < IB; b++)
          if (reg_addr_i == OFS_IVAL + REG_AW'(b))
            stage_q[b*8 +: 8] <= reg_wdata_i & IMASK[b*8 +: 8];
        for (int b = 0; b < NB; b++)
          if (reg_addr_i == OFS_ENA + REG_AW'(b))
            ena_q[b*8 +: 8] <= reg_wdata_i;
      end
      if (reload) act_q <= stage_q[IVAL_W-1:0];
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    for (int b = 0; b < NB; b++) begin
      if (reg_addr_i == OFS_LEVEL + REG_AW'(b)) reg_rdata_o = level_i[b*8 +: 8];
      if (reg_addr_i == OFS_ENA + REG_AW'(b))   reg_rdata_o = ena_q[b*8 +: 8];
    end
    for (int b = 0; b < IB; b++)
      if (reg_addr_i == OFS_IVAL + REG_AW'(b)) reg_rdata_o = stage_q[b*8 +: 8];
  end

  assign ena_o  = ena_q;
  assign ival_o = act_q;

  // R4: the active interval moves only on a reload command
  p_active_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_i && reg_addr_i == OFS_CMD && reg_wdata_i[CMD_RELOAD_BIT]) |=> $stable(ival_o));
  // R3: unused interval bits always read as zero
  p_stage_nibble_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr_i == OFS_IVAL + REG_AW'(IB-1) |-> ((reg_rdata_o & ~IMASK[(IB-1)*8 +: 8]) == 8'h00));
endmodule

// File: rtl/dinflt_chan.sv
module dinflt_chan #(
  parameter int unsigned IVAL_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              din_i,
  input  logic              tick_i,
  input  logic              filt_en_i,
  input  logic [IVAL_W-1:0] ival_i,
  input  logic              clear_i,
  output logic              q_o
);
  logic [1:0]        sync_q;
  logic              lvl;
  logic [IVAL_W-1:0] cnt_q;
  logic [IVAL_W:0]   cnt_nxt;

  assign lvl     = sync_q[1];
  assign cnt_nxt = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], din_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_o   <= 1'b0;
      cnt_q <= '0;
    end else if (clear_i || !filt_en_i) begin
      q_o   <= lvl;
      cnt_q <= '0;
    end else if (lvl == q_o) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (cnt_nxt >= {1'b0, ival_i}) begin
        q_o   <= lvl;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_nxt[IVAL_W-1:0];
      end
    end
  end

  // R5: a filtered output can only move in a tick cycle
  p_hold_between_ticks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !clear_i && filt_en_i) |=> $stable(q_o));
  // R7: unfiltered channel follows the synchronizer
  p_bypass_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !filt_en_i |=> (q_o == $past(lvl)));
  // R8: clear command reloads from the synchronizer
  p_clear_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (q_o == $past(lvl)));
endmodule

// File: rtl/din_glitch_filter.sv
module din_glitch_filter
  import dinflt_pkg::*;
#(
  parameter int unsigned N_CH     = 24,
  parameter int unsigned IVAL_W   = 20,
  parameter int unsigned TICK_DIV = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_CH-1:0]   din_i,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic [N_CH-1:0]   filt_o
);
  logic              tick;
  logic [N_CH-1:0]   ena;
  logic [IVAL_W-1:0] ival;
  logic              clear;
  logic              ival_zero;

  assign ival_zero = (ival == '0);

  dinflt_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick)
  );

  dinflt_regs #(.N_CH(N_CH), .IVAL_W(IVAL_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .level_i     (filt_o),
    .ena_o       (ena),
    .ival_o      (ival),
    .clear_o     (clear)
  );

  generate
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
      dinflt_chan #(.IVAL_W(IVAL_W)) u_chan (
        .clk       (clk),
        .rst_n     (rst_n),
        .din_i     (din_i[c]),
        .tick_i    (tick),
        .filt_en_i (ena[c] && !ival_zero),
        .ival_i    (ival),
        .clear_i   (clear),
        .q_o       (filt_o[c])
      );
    end
  endgenerate

  // R1: the first cycle after reset has an empty enable mask
  p_reset_mask_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (ena == '0) && (ival == '0));
endmodule

// File: tb/din_glitch_filter_tb_top.sv
module din_glitch_filter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TICKDIV    = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] din = '0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [23:0] filt;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  din_glitch_filter #(.N_CH(24), .IVAL_W(20), .TICK_DIV(TICKDIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .din_i(din), .reg_wr_i(reg_wr),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .filt_o(filt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic set_ival(input logic [19:0] v);
    wr(5'h08, v[7:0]); wr(5'h09, v[15:8]); wr(5'h0A, {4'h0, v[19:16]});
    wr(5'h07, 8'h01);
  endtask

  // watch one channel for n cycles, return 1 if it was ever high
  task automatic watch(input int ch, input int n, output logic seen);
    seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (filt[ch]) seen = 1'b1;
    end
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 filt reset", 32'(filt), 32'h0);
    for (int a = 8; a < 15; a++) begin
      rd(5'(a), d);
      chk("R1 regs zero", 32'(d), 32'h0);
    end
    rd(5'h05, d); chk("R1 unmapped 05", 32'(d), 32'h0);
    rd(5'h1F, d); chk("R1 unmapped 1F", 32'(d), 32'h0);
  endtask

  task automatic t_sync;
    logic [7:0] d;
    @(negedge clk); din = 24'hA53C0F;
    cyc(2);
    chk("R2 not yet after two edges", 32'(filt), 32'h0);
    cyc(1);
    chk("R2 visible after three edges", 32'(filt), 32'hA53C0F);
    rd(5'h00, d); chk("R3 byte0", 32'(d), 32'h0F);
    rd(5'h01, d); chk("R3 byte1", 32'(d), 32'h3C);
    rd(5'h02, d); chk("R3 byte2", 32'(d), 32'hA5);
    din = '0; cyc(4);
  endtask

  task automatic t_stage;
    logic [7:0] d;
    logic seen;
    wr(5'h0C, 8'hFF); wr(5'h0D, 8'hFF); wr(5'h0E, 8'hFF);
    wr(5'h08, 8'h04); wr(5'h09, 8'h00); wr(5'h0A, 8'hF0);
    rd(5'h0A, d); chk("R3 upper nibble dropped", 32'(d), 32'h0);
    rd(5'h08, d); chk("R3 staged low byte", 32'(d), 32'h04);
    rd(5'h0C, d); chk("R9 enable readback", 32'(d), 32'hFF);
    din[0] = 1'b1; cyc(3);
    chk("R4 staged interval inert", 32'(filt[0]), 32'h1);
    din[0] = 1'b0; cyc(4);
    wr(5'h07, 8'h01);
    din[0] = 1'b1; cyc(15); din[0] = 1'b0;
    watch(0, 40, seen);
    chk("R4 reloaded interval filters pulse", 32'(seen), 32'h0);
  endtask

  task automatic t_filter;
    logic seen;
    @(negedge clk); din[0] = 1'b1; cyc(24); din[0] = 1'b0;
    watch(0, 60, seen);
    chk("R5 short glitch suppressed", 32'(seen), 32'h0);
    din[0] = 1'b1; cyc(28);
    chk("R5 not before interval", 32'(filt[0]), 32'h0);
    cyc(27);
    chk("R5 passes after interval", 32'(filt[0]), 32'h1);
    din[0] = 1'b0; cyc(60);
    chk("R5 falling level passes", 32'(filt[0]), 32'h0);
  endtask

  task automatic t_bounce;
    @(negedge clk); din[0] = 1'b1; cyc(25);
    din[0] = 1'b0; cyc(2);
    din[0] = 1'b1; cyc(25);
    chk("R6 count restarted by bounce", 32'(filt[0]), 32'h0);
    cyc(40);
    chk("R6 passes after restart", 32'(filt[0]), 32'h1);
    din[0] = 1'b0; cyc(60);
  endtask

  task automatic t_zero;
    set_ival(20'h0);
    @(negedge clk); din = 24'hFFFFFF; cyc(3);
    chk("R7 zero interval passthrough", 32'(filt), 32'hFFFFFF);
    din = '0; cyc(4);
  endtask

  task automatic t_clear;
    set_ival(20'h003FF);
    @(negedge clk); din[7:0] = 8'hFF; cyc(50);
    chk("R8 long interval holds", 32'(filt[7:0]), 32'h0);
    wr(5'h07, 8'h02);
    chk("R8 clear loads input", 32'(filt[7:0]), 32'hFF);
    din[7:0] = 8'h00; cyc(3);
    wr(5'h07, 8'h02);
    chk("R8 clear loads low", 32'(filt[7:0]), 32'h00);
  endtask

  task automatic t_chan;
    logic seen;
    set_ival(20'h4);
    wr(5'h0C, 8'h20); wr(5'h0D, 8'h00); wr(5'h0E, 8'h80);
    @(negedge clk); din[6:5] = 2'b11; din[23:22] = 2'b11; cyc(15);
    chk("R9 ch6 unfiltered", 32'(filt[6]), 32'h1);
    chk("R9 ch22 unfiltered", 32'(filt[22]), 32'h1);
    chk("R9 ch5 filtered", 32'(filt[5]), 32'h0);
    chk("R9 ch23 filtered", 32'(filt[23]), 32'h0);
    din = '0;
    watch(5, 60, seen);
    chk("R9 ch5 never passed", 32'(seen), 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_sync();
    t_stage();
    t_filter();
    t_bounce();
    t_zero();
    t_clear();
    t_chan();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule